// File: doc/BRIEF.md
# Cascadable 16-bit Instruction ALU

This block is a 16-bit arithmetic and logic unit steered by a 5-bit opcode. Each of its two operands comes through its own four-way selector, which picks the live input port, the value that port carried one cycle earlier, or one of two register-file feedback buses. The selected operands are combined by the instruction, and the result and a status flag are captured on the rising clock edge.

Each arithmetic instruction has three carry variants. The low-word form starts from a fixed carry. The chained form takes its carry from an input pin and drives its own carry out in the same cycle, so several units can sit side by side and form a wider word at full rate. The multi-pass form takes its carry from the carry that the previous arithmetic instruction registered, so one unit can process a wide word one 16-bit half per cycle, low half first. A clear instruction zeroes every datapath register and returns the flag to overflow reporting. Three instructions emit fixed bit patterns.

Top module: `cascade_alu`

## Requirements
- R1: While rst_n is low, result and flag are 0. After reset the flag reports signed overflow.
- R2: Operand selector encoding, for both a_src and b_src: 0 = live port, 1 = value the port held one cycle earlier, 2 = rf_alu, 3 = rf_shf.
- R3: Logic opcodes: 1 passes A, 2 passes B, 3 gives ~A, 4 gives ~B, 5 gives A&B, 6 gives A|B, 7 gives A^B, 8 gives A&~B. The result appears one edge later.
- R4: Opcodes 18, 19 and 20 produce 16'h00FF, 16'h000F and 16'h5555 whatever the operands are.
- R5: Low-word arithmetic: opcode 9 gives A+B with carry-in 0. Opcode 12 gives A−B and opcode 15 gives B−A, both as X+~Y+1. Carry 1 means no borrow.
- R6: Chained variants (opcodes 10, 13, 16) use the carry_in pin as carry-in. carry_out shows the carry of the current operation in the same cycle.
- R7: Multi-pass variants (opcodes 11, 14, 17) use the carry registered by the most recent arithmetic instruction.
- R8: Clear (opcode 0) zeroes the result, both held operands and the registered carry, and sets the flag to report overflow.
- R9: After an arithmetic instruction, flag holds the signed overflow of the result in overflow mode, or the carry in carry mode. Opcode 21 selects carry mode and opcode 22 selects overflow mode. After any other instruction, flag is 0.
- R10: Opcodes 23 to 31 and the flag-mode opcodes leave result and the registered carry unchanged.
- R11: carry_out is 0 during any non-arithmetic instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 5 | Instruction code |
| a_src | input | 2 | A operand selector |
| b_src | input | 2 | B operand selector |
| a_port | input | 16 | A data input |
| b_port | input | 16 | B data input |
| rf_alu | input | 16 | ALU register-file feedback |
| rf_shf | input | 16 | Shifter register-file feedback |
| carry_in | input | 1 | Carry from a lower chained unit |
| result | output | 16 | Registered result |
| carry_out | output | 1 | Same-cycle carry of the current arithmetic operation |
| flag | output | 1 | Registered overflow or carry flag |

## Verification
Four properties are checked on every cycle: a clear forces a zero result, the 5555 pattern appears, carry_out stays quiet and the flag drops after non-arithmetic instructions, and the no-operation codes hold the result. The bench scenarios cover what needs history or arithmetic. These are the 32-bit sums and differences built in two passes through the registered carry, the carry chained from the pin, the one-cycle operand hold and its clearing, and the switch between carry and overflow reporting.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_CLR    = 5'd0,
        OP_PASA   = 5'd1,
        OP_PASB   = 5'd2,
        OP_NOTA   = 5'd3,
        OP_NOTB   = 5'd4,
        OP_AND    = 5'd5,
        OP_OR     = 5'd6,
        OP_XOR    = 5'd7,
        OP_ANDN   = 5'd8,
        OP_ADD_LO = 5'd9,
        OP_ADD_CH = 5'd10,
        OP_ADD_MP = 5'd11,
        OP_AMB_LO = 5'd12,
        OP_AMB_CH = 5'd13,
        OP_AMB_MP = 5'd14,
        OP_BMA_LO = 5'd15,
        OP_BMA_CH = 5'd16,
        OP_BMA_MP = 5'd17,
        OP_K_HALF = 5'd18,
        OP_K_QRT  = 5'd19,
        OP_K_ALT  = 5'd20,
        OP_FLG_CY = 5'd21,
        OP_FLG_OV = 5'd22
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_PORT = 2'd0,
        SRC_HELD = 2'd1,
        SRC_RFA  = 2'd2,
        SRC_RFS  = 2'd3
    } opnd_src_e;

    typedef enum logic [1:0] {
        CY_FIXED = 2'd0,
        CY_PIN   = 2'd1,
        CY_REG   = 2'd2
    } cy_src_e;

    typedef enum logic [1:0] {
        AR_ADD = 2'd0,
        AR_AMB = 2'd1,
        AR_BMA = 2'd2
    } ar_kind_e;

    function automatic logic is_arith(input logic [4:0] op);
        return (op >= 5'd9) && (op <= 5'd17);
    endfunction

    function automatic logic is_hold(input logic [4:0] op);
        return op >= 5'd21;
    endfunction

    function automatic logic [15:0] alt_pattern16();
        logic [15:0] p;
        for (int i = 0; i < 16; i++) p[i] = ~i[0];
        return p;
    endfunction

endpackage

// File: rtl/alu_opnd_mux.sv
module alu_opnd_mux #(
    parameter int W = 16
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] port_val,
    input  logic [W-1:0] held_val,
    input  logic [W-1:0] rfa_val,
    input  logic [W-1:0] rfs_val,
    output logic [W-1:0] opnd
);
    import alu_pkg::*;

    always_comb begin
        case (opnd_src_e'(sel))
            SRC_PORT: opnd = port_val;
            SRC_HELD: opnd = held_val;
            SRC_RFA:  opnd = rfa_val;
            default:  opnd = rfs_val;
        endcase
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 16
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin_pin,
    input  logic         cin_reg,
    output logic         active,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    import alu_pkg::*;

    ar_kind_e       kind;
    cy_src_e        csrc;
    logic [W-1:0]   x, y;
    logic           cin;
    logic [W:0]     total;

    always_comb begin
        active = 1'b1;
        kind   = AR_ADD;
        csrc   = CY_FIXED;
        case (alu_op_e'(op))
            OP_ADD_LO: begin kind = AR_ADD; csrc = CY_FIXED; end
            OP_ADD_CH: begin kind = AR_ADD; csrc = CY_PIN;   end
            OP_ADD_MP: begin kind = AR_ADD; csrc = CY_REG;   end
            OP_AMB_LO: begin kind = AR_AMB; csrc = CY_FIXED; end
            OP_AMB_CH: begin kind = AR_AMB; csrc = CY_PIN;   end
            OP_AMB_MP: begin kind = AR_AMB; csrc = CY_REG;   end
            OP_BMA_LO: begin kind = AR_BMA; csrc = CY_FIXED; end
            OP_BMA_CH: begin kind = AR_BMA; csrc = CY_PIN;   end
            OP_BMA_MP: begin kind = AR_BMA; csrc = CY_REG;   end
            default:   active = 1'b0;
        endcase
    end

    always_comb begin
        case (kind)
            AR_AMB:  begin x = a; y = ~b; end
            AR_BMA:  begin x = b; y = ~a; end
            default: begin x = a; y = b;  end
        endcase
        case (csrc)
            CY_PIN:  cin = cin_pin;
            CY_REG:  cin = cin_reg;
            default: cin = (kind != AR_ADD);
        endcase
        total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum   = total[W-1:0];
        cout  = active & total[W];
        ovf   = active & (x[W-1] == y[W-1]) & (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 16
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] out
);
    import alu_pkg::*;

    localparam int HALF = W / 2;
    localparam int QRT  = W / 4;

    logic [W-1:0] k_half, k_qrt, k_alt;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_const
            assign k_half[g] = (g < HALF);
            assign k_qrt[g]  = (g < QRT);
            assign k_alt[g]  = ((g % 2) == 0);
        end
    endgenerate

    always_comb begin
        case (alu_op_e'(op))
            OP_PASA:   out = a;
            OP_PASB:   out = b;
            OP_NOTA:   out = ~a;
            OP_NOTB:   out = ~b;
            OP_AND:    out = a & b;
            OP_OR:     out = a | b;
            OP_XOR:    out = a ^ b;
            OP_ANDN:   out = a & ~b;
            OP_K_HALF: out = k_half;
            OP_K_QRT:  out = k_qrt;
            OP_K_ALT:  out = k_alt;
            default:   out = '0;
        endcase
    end
endmodule

// File: rtl/cascade_alu.sv
module cascade_alu #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   opcode,
    input  logic [1:0]   a_src,
    input  logic [1:0]   b_src,
    input  logic [W-1:0] a_port,
    input  logic [W-1:0] b_port,
    input  logic [W-1:0] rf_alu,
    input  logic [W-1:0] rf_shf,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         flag
);
    import alu_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
        logic [W-1:0] a_held;
        logic [W-1:0] b_held;
        logic         cy;
        logic         flg;
        logic         ov_mode;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic [W-1:0] opa, opb, ar_sum, lg_out;
    logic         ar_act, ar_cout, ar_ovf;

    alu_opnd_mux #(.W(W)) i_mux_a (
        .sel(a_src), .port_val(a_port), .held_val(st_q.a_held),
        .rfa_val(rf_alu), .rfs_val(rf_shf), .opnd(opa)
    );

    alu_opnd_mux #(.W(W)) i_mux_b (
        .sel(b_src), .port_val(b_port), .held_val(st_q.b_held),
        .rfa_val(rf_alu), .rfs_val(rf_shf), .opnd(opb)
    );

    alu_arith #(.W(W)) i_arith (
        .op(opcode), .a(opa), .b(opb), .cin_pin(carry_in), .cin_reg(st_q.cy),
        .active(ar_act), .sum(ar_sum), .cout(ar_cout), .ovf(ar_ovf)
    );

    alu_logic #(.W(W)) i_logic (
        .op(opcode), .a(opa), .b(opb), .out(lg_out)
    );

    always_comb begin
        st_d        = st_q;
        st_d.a_held = a_port;
        st_d.b_held = b_port;
        st_d.flg    = 1'b0;
        if (opcode == OP_CLR) begin
            st_d.res     = '0;
            st_d.a_held  = '0;
            st_d.b_held  = '0;
            st_d.cy      = 1'b0;
            st_d.ov_mode = 1'b1;
        end else if (ar_act) begin
            st_d.res = ar_sum;
            st_d.cy  = ar_cout;
            st_d.flg = st_q.ov_mode ? ar_ovf : ar_cout;
        end else if (opcode == OP_FLG_CY) begin
            st_d.ov_mode = 1'b0;
        end else if (opcode == OP_FLG_OV) begin
            st_d.ov_mode = 1'b1;
        end else if (!is_hold(opcode)) begin
            st_d.res = lg_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.ov_mode <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.res;
    assign flag      = st_q.flg;
    assign carry_out = ar_cout;

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_CLR) |=> (result == '0));

    assert_alt_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_K_ALT) |=> (result[15:0] == alt_pattern16()));

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_hold(opcode) |=> $stable(result));

    assert_quiet_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_arith(opcode) |-> !carry_out);

    assert_flag_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_arith(opcode) |=> !flag);
endmodule

// File: tb/test_cascade_alu.sv
module test_cascade_alu;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  opcode = 5'd23;
    logic [1:0]  a_src = 2'd0, b_src = 2'd0;
    logic [15:0] a_port = '0, b_port = '0, rf_alu = '0, rf_shf = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        carry_out, flag;
    logic        cout_s;
    int total = 0, bad = 0;

    cascade_alu i_cascade_alu (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .a_src(a_src), .b_src(b_src),
        .a_port(a_port), .b_port(b_port), .rf_alu(rf_alu), .rf_shf(rf_shf),
        .carry_in(carry_in), .result(result), .carry_out(carry_out), .flag(flag)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // drive at a negedge, sample carry_out mid-cycle, return at next negedge
    task automatic step(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic [1:0] as, input logic [1:0] bs, input logic ci);
        opcode = op; a_port = a; b_port = b; a_src = as; b_src = bs; carry_in = ci;
        #1 cout_s = carry_out;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        check("R1 result in reset", result, 16'h0);
        check("R1 flag in reset", {15'b0, flag}, 16'h0);
        rst_n = 1'b1;
        step(5'd9, 16'h7FFF, 16'h0001, 0, 0, 0);
        check("R1 overflow mode after reset", {15'b0, flag}, 16'h1);
    endtask

    task automatic t_logic();
        step(5'd5, 16'hF0F0, 16'h3C3C, 0, 0, 0); check("R3 and", result, 16'h3030);
        check("R11 cout on logic", {15'b0, cout_s}, 16'h0);
        step(5'd6, 16'hF0F0, 16'h3C3C, 0, 0, 0); check("R3 or", result, 16'hFCFC);
        step(5'd7, 16'hF0F0, 16'h3C3C, 0, 0, 0); check("R3 xor", result, 16'hCCCC);
        step(5'd8, 16'hF0F0, 16'h3C3C, 0, 0, 0); check("R3 andn", result, 16'hC0C0);
        step(5'd3, 16'h1234, 16'h0, 0, 0, 0);    check("R3 nota", result, 16'hEDCB);
        check("R9 flag after logic", {15'b0, flag}, 16'h0);
    endtask

    task automatic t_const();
        step(5'd18, 16'h1111, 16'h2222, 0, 0, 0); check("R4 00FF", result, 16'h00FF);
        step(5'd19, 16'h1111, 16'h2222, 0, 0, 0); check("R4 000F", result, 16'h000F);
        step(5'd20, 16'h1111, 16'h2222, 0, 0, 0); check("R4 5555", result, 16'h5555);
    endtask

    task automatic t_mux();
        step(5'd1, 16'h1234, 16'hABCD, 0, 0, 0);
        step(5'd1, 16'h0000, 16'h0000, 1, 0, 0); check("R2 held a", result, 16'h1234);
        step(5'd2, 16'h0000, 16'h0000, 0, 1, 0); check("R2 held b", result, 16'h0000);
        rf_alu = 16'h0100; rf_shf = 16'h0023;
        step(5'd9, 16'h0, 16'h0, 2, 3, 0);       check("R2 rf operands", result, 16'h0123);
    endtask

    task automatic t_arith();
        step(5'd12, 16'h0005, 16'h0003, 0, 0, 0); check("R5 a-b", result, 16'h0002);
        check("R5 no-borrow carry", {15'b0, cout_s}, 16'h1);
        step(5'd15, 16'h0005, 16'h0003, 0, 0, 0); check("R5 b-a", result, 16'hFFFE);
        check("R5 borrow carry", {15'b0, cout_s}, 16'h0);
        step(5'd10, 16'h7FFF, 16'h0000, 0, 0, 1); check("R6 chained add", result, 16'h8000);
        check("R6 chained cout", {15'b0, cout_s}, 16'h0);
        check("R9 overflow flag", {15'b0, flag}, 16'h1);
        step(5'd10, 16'hFFFF, 16'h0000, 0, 0, 1); check("R6 chained wrap", result, 16'h0000);
        check("R6 same-cycle cout", {15'b0, cout_s}, 16'h1);
        // 32-bit 0x0001FFFF + 0x00000001
        step(5'd9, 16'hFFFF, 16'h0001, 0, 0, 0);  check("R7 low half", result, 16'h0000);
        step(5'd11, 16'h0001, 16'h0000, 0, 0, 0); check("R7 high half add", result, 16'h0002);
        // 32-bit 0x00010000 - 0x00000001
        step(5'd12, 16'h0000, 16'h0001, 0, 0, 0); check("R7 low sub", result, 16'hFFFF);
        step(5'd14, 16'h0001, 16'h0000, 0, 0, 0); check("R7 high sub", result, 16'h0000);
    endtask

    task automatic t_flag_mode();
        step(5'd21, 16'h0, 16'h0, 0, 0, 0);
        step(5'd9, 16'hFFFF, 16'h0001, 0, 0, 0); check("R9 carry mode flag", {15'b0, flag}, 16'h1);
        step(5'd9, 16'h7FFF, 16'h0001, 0, 0, 0); check("R9 carry mode no ovf", {15'b0, flag}, 16'h0);
        step(5'd22, 16'h0, 16'h0, 0, 0, 0);
        step(5'd9, 16'h7FFF, 16'h0001, 0, 0, 0); check("R9 ovf mode", {15'b0, flag}, 16'h1);
    endtask

    task automatic t_hold();
        step(5'd9, 16'hFFFF, 16'h0001, 0, 0, 0);
        step(5'd18, 16'h0, 16'h0, 0, 0, 0);
        step(5'd27, 16'h5A5A, 16'h1111, 0, 0, 0); check("R10 nop keeps result", result, 16'h00FF);
        step(5'd31, 16'h5A5A, 16'h1111, 0, 0, 0); check("R10 nop 31 keeps result", result, 16'h00FF);
        step(5'd9, 16'hFFFF, 16'h0001, 0, 0, 0);
        step(5'd25, 16'h0, 16'h0, 0, 0, 0);
        step(5'd11, 16'h0000, 16'h0000, 0, 0, 0); check("R10 nop keeps carry", result, 16'h0001);
    endtask

    task automatic t_clear();
        step(5'd21, 16'h0, 16'h0, 0, 0, 0);
        step(5'd9, 16'hFFFF, 16'h0001, 0, 0, 0);
        step(5'd0, 16'h4444, 16'h5555, 0, 0, 0); check("R8 clear result", result, 16'h0000);
        step(5'd11, 16'h0001, 16'h0001, 0, 0, 0); check("R8 carry cleared", result, 16'h0002);
        step(5'd0, 16'h4444, 16'h5555, 0, 0, 0);
        step(5'd6, 16'h9999, 16'h9999, 1, 1, 0); check("R8 held zeroed", result, 16'h0000);
        step(5'd9, 16'h7FFF, 16'h0001, 0, 0, 0); check("R8 ovf mode restored", {15'b0, flag}, 16'h1);
    endtask

    initial begin
        t_reset();
        t_logic();
        t_const();
        t_mux();
        t_arith();
        t_flag_mode();
        t_hold();
        t_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule